// File: doc/BRIEF.md
# Interlaced LCD Row Scan Sequencer

This block produces the row-select timing for a multiplexed dot-matrix LCD of up to 34 rows. Each single-cycle row tick moves the scan to the next row. The scan runs in interlaced order: every even row first, then every odd row, then back to row 0. The scan length is programmable, so a panel with fewer rows can be driven. Rows at or above the programmed count are never driven.

The block puts out a fetch address, which is the row it will select next. An external display latch must return that row's column data on `col_data_i` in the same cycle. On each tick the block registers the fetched row as the active row and drives three things: a one-hot row vector, the row index and the captured column word. It also gives a one-cycle pulse whenever row 0 becomes active.

Two reset sources exist: a power-on reset and an external reset pin. A select input decides which of the two is honoured. The chosen reset asserts asynchronously and releases synchronously. Reset, and the power-down input, both blank every output and park the scan at row 0.

Top module: `lcd_row_scan`

## Requirements
- R1: With a scan length of N, successive ticks select 0, 2, 4, … (the even rows below N), then 1, 3, 5, … (the odd rows below N), then row 0 again. With N = 1 only row 0 is selected.
- R2: No row with index greater than or equal to the active scan length is ever selected, and its bit in `row_sel_o` stays 0.
- R3: A programmed `mux_rate_i` of 0, or of any value above 34, is treated as 34.
- R4: A new `mux_rate_i` takes effect only at a frame boundary. It is sampled on the tick that wraps the fetch address back to 0, and also whenever the block is in reset or power-down. A change in the middle of a frame leaves the rest of that frame unchanged.
- R5: `row_sel_o` has exactly the bit `row_idx_o` set while a row is active, and is all zero otherwise. `frame_o` is 1 for the single cycle after the tick that selects row 0.
- R6: `fetch_addr_o` shows the row that the next tick will select. On that tick, `col_o` takes the value `col_data_i` had in that cycle.
- R7: While `pd_i` is 1, the following hold from the next clock edge on: `row_sel_o`, `row_idx_o`, `col_o` and `frame_o` are 0, `fetch_addr_o` is 0, and ticks have no effect. The first tick after `pd_i` returns to 0 selects row 0.
- R8: When `rst_sel_i` = 0 the power-on reset `por_i` is honoured and `ext_rst_i` is ignored. When `rst_sel_i` = 1 the converse holds.
- R9: The honoured reset blanks all outputs from the next clock edge. The blanking lasts until two clock edges after the reset is released, and the first tick after that selects row 0.
- R10: Between ticks, all outputs hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_i | input | 1 | Power-on reset source, active high |
| ext_rst_i | input | 1 | External reset source, active high |
| rst_sel_i | input | 1 | 0 honours `por_i`, 1 honours `ext_rst_i` |
| pd_i | input | 1 | Power-down, active high |
| row_tick_i | input | 1 | Single-cycle advance strobe |
| mux_rate_i | input | 6 | Programmed number of rows to scan |
| col_data_i | input | 128 | Latch data for the row at `fetch_addr_o` |
| fetch_addr_o | output | 6 | Row the next tick will select |
| row_sel_o | output | 34 | One-hot active row |
| row_idx_o | output | 6 | Active row index |
| col_o | output | 128 | Column data of the active row |
| frame_o | output | 1 | One-cycle pulse when row 0 becomes active |

## Verification
The assertions assume that `row_tick_i` is a clean synchronous strobe. They also assume that `col_data_i` is settled within the cycle that `fetch_addr_o` is shown, and that the reset sources change only away from the clock edge. The bench drives every input at the falling edge. It models the display latch as a pure function of the fetch address, so the data is always consistent. Random stimulus mixes tick densities, scan lengths (including 0, 1 and values above 34), changes of length in the middle of a frame, and brief power-down episodes. Directed segments cover each reset source being honoured and each being ignored.

// File: rtl/lcd_row_scan_pkg.sv
package lcd_row_scan_pkg;

  // Interlaced successor of row r for a scan of n rows
  function automatic int next_row(input int r, input int n);
    if (r % 2 == 0) begin
      if (r + 2 < n) return r + 2;
      return (n > 1) ? 1 : 0;
    end
    if (r + 2 < n) return r + 2;
    return 0;
  endfunction

  // Out-of-range rate falls back to the full panel
  function automatic int clamp_rate(input int m, input int max_rows);
    if (m == 0 || m > max_rows) return max_rows;
    return m;
  endfunction

endpackage

// File: rtl/lcd_rst_sync.sv
module lcd_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic raw_i,
  output logic rst_o
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or posedge raw_i) begin
    if (raw_i) sh_q <= '1;
    else       sh_q <= {sh_q[STAGES-2:0], 1'b0};
  end

  assign rst_o = sh_q[STAGES-1];
endmodule

// File: rtl/lcd_scan_ctrl.sv
module lcd_scan_ctrl
  import lcd_row_scan_pkg::*;
#(
  parameter int MAX_ROWS = 34,
  localparam int IDX_W = $clog2(MAX_ROWS),
  localparam int CNT_W = $clog2(MAX_ROWS + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pd_i,
  input  logic             row_tick_i,
  input  logic [CNT_W-1:0] mux_rate_i,
  output logic [IDX_W-1:0] fetch_o,
  output logic             adv_o
);
  logic [IDX_W-1:0] fetch_q;
  logic [CNT_W-1:0] rate_q;
  logic [IDX_W-1:0] nxt;
  logic [CNT_W-1:0] rate_new;

  always_comb begin
    nxt      = IDX_W'(next_row(int'(fetch_q), int'(rate_q)));
    rate_new = CNT_W'(clamp_rate(int'(mux_rate_i), MAX_ROWS));
  end

  assign adv_o = row_tick_i && !pd_i && !rst;

  always_ff @(posedge clk) begin
    if (rst || pd_i) begin
      fetch_q <= '0;
      rate_q  <= rate_new;
    end else if (row_tick_i) begin
      fetch_q <= nxt;
      if (nxt == '0) rate_q <= rate_new;
    end
  end

  assign fetch_o = fetch_q;

  AST_FETCH_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    CNT_W'(fetch_q) < rate_q) else $error("fetch out of range"); // R2
  AST_RATE_NONZERO: assert property (@(posedge clk) disable iff (rst)
    rate_q != '0 && rate_q <= CNT_W'(MAX_ROWS)) else $error("rate bad"); // R3
  AST_RATE_FRAME_ONLY: assert property (@(posedge clk) disable iff (rst)
    (!pd_i && !(row_tick_i && nxt == '0)) |=> $stable(rate_q)) else $error("rate changed mid-frame"); // R4
endmodule

// File: rtl/lcd_row_drive.sv
module lcd_row_drive #(
  parameter int MAX_ROWS = 34,
  parameter int COLS     = 128,
  localparam int IDX_W = $clog2(MAX_ROWS)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                pd_i,
  input  logic                adv_i,
  input  logic [IDX_W-1:0]    fetch_i,
  input  logic [COLS-1:0]     col_data_i,
  output logic [MAX_ROWS-1:0] row_sel_o,
  output logic [IDX_W-1:0]    row_idx_o,
  output logic [COLS-1:0]     col_o,
  output logic                frame_o
);
  logic             act_q;
  logic [IDX_W-1:0] idx_q;
  logic [COLS-1:0]  col_q;
  logic             frame_q;

  always_ff @(posedge clk) begin
    if (rst || pd_i) begin
      act_q   <= 1'b0;
      idx_q   <= '0;
      col_q   <= '0;
      frame_q <= 1'b0;
    end else begin
      frame_q <= adv_i && (fetch_i == '0);
      if (adv_i) begin
        act_q <= 1'b1;
        idx_q <= fetch_i;
        col_q <= col_data_i;
      end
    end
  end

  for (genvar g = 0; g < MAX_ROWS; g++) begin : g_row
    logic sel_q;
    always_ff @(posedge clk) begin
      if (rst || pd_i)  sel_q <= 1'b0;
      else if (adv_i)   sel_q <= (fetch_i == IDX_W'(g));
    end
    assign row_sel_o[g] = sel_q;
  end

  assign row_idx_o = idx_q;
  assign col_o     = col_q;
  assign frame_o   = frame_q;

  AST_ONEHOT_ROW: assert property (@(posedge clk) disable iff (rst)
    act_q |-> $onehot(row_sel_o)) else $error("row vector not one-hot"); // R5
  AST_IDLE_BLANK: assert property (@(posedge clk) disable iff (rst)
    !act_q |-> (row_sel_o == '0 && col_q == '0)) else $error("idle not blank"); // R7
  AST_PD_QUIET: assert property (@(posedge clk) disable iff (rst)
    pd_i |=> (row_sel_o == '0 && !frame_q && col_q == '0)) else $error("power-down not quiet"); // R7
  AST_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!adv_i && !pd_i) |=> ($stable(idx_q) && $stable(row_sel_o) && $stable(col_q))) else $error("drift"); // R10
endmodule

// File: rtl/lcd_row_scan.sv
module lcd_row_scan #(
  parameter int MAX_ROWS = 34,
  parameter int COLS     = 128,
  localparam int IDX_W = $clog2(MAX_ROWS),
  localparam int CNT_W = $clog2(MAX_ROWS + 1)
) (
  input  logic                clk,
  input  logic                por_i,
  input  logic                ext_rst_i,
  input  logic                rst_sel_i,
  input  logic                pd_i,
  input  logic                row_tick_i,
  input  logic [CNT_W-1:0]    mux_rate_i,
  input  logic [COLS-1:0]     col_data_i,
  output logic [IDX_W-1:0]    fetch_addr_o,
  output logic [MAX_ROWS-1:0] row_sel_o,
  output logic [IDX_W-1:0]    row_idx_o,
  output logic [COLS-1:0]     col_o,
  output logic                frame_o
);
  logic raw_rst;
  logic rst;
  logic adv;

  assign raw_rst = rst_sel_i ? ext_rst_i : por_i;

  lcd_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .raw_i(raw_rst), .rst_o(rst)
  );

  lcd_scan_ctrl #(.MAX_ROWS(MAX_ROWS)) u_ctrl (
    .clk(clk), .rst(rst), .pd_i(pd_i), .row_tick_i(row_tick_i),
    .mux_rate_i(mux_rate_i), .fetch_o(fetch_addr_o), .adv_o(adv)
  );

  lcd_row_drive #(.MAX_ROWS(MAX_ROWS), .COLS(COLS)) u_drive (
    .clk(clk), .rst(rst), .pd_i(pd_i), .adv_i(adv), .fetch_i(fetch_addr_o),
    .col_data_i(col_data_i), .row_sel_o(row_sel_o), .row_idx_o(row_idx_o),
    .col_o(col_o), .frame_o(frame_o)
  );

  AST_RST_BLANK: assert property (@(posedge clk)
    rst |=> (row_sel_o == '0 && !frame_o && fetch_addr_o == '0)) else $error("reset not blank"); // R9
  AST_FRAME_ROW0: assert property (@(posedge clk) disable iff (rst)
    frame_o |-> (row_idx_o == '0 && row_sel_o[0])) else $error("frame pulse off row 0"); // R5
endmodule

// File: tb/tb_lcd_row_scan.sv
module tb_lcd_row_scan;
  localparam int MAX_ROWS = 34;
  localparam int COLS = 128;

  logic clk = 1'b0;
  logic por_i = 1'b1, ext_rst_i = 1'b0, rst_sel_i = 1'b0, pd_i = 1'b0, row_tick_i = 1'b0;
  logic [5:0] mux_rate_i = 6'd34;
  logic [COLS-1:0] col_data_i;
  logic [5:0] fetch_addr_o, row_idx_o;
  logic [MAX_ROWS-1:0] row_sel_o;
  logic [COLS-1:0] col_o;
  logic frame_o;

  int errors = 0, checks = 0;
  int m_fetch, m_rate, m_idx;
  bit m_act, m_frame;
  logic [COLS-1:0] m_col;

  always #10 clk = ~clk;

  function automatic logic [COLS-1:0] pat(input int a);
    logic [COLS-1:0] v;
    for (int i = 0; i < COLS / 32; i++)
      v[i*32 +: 32] = 32'(a * 32'h9E3779B1) ^ 32'(i * 32'h01010101) ^ 32'h5A5A0000;
    return v;
  endfunction

  function automatic int nxt(input int r, input int n);
    if (r % 2 == 0) return (r + 2 < n) ? r + 2 : ((n > 1) ? 1 : 0);
    return (r + 2 < n) ? r + 2 : 0;
  endfunction

  function automatic int clampr(input int m);
    return (m == 0 || m > MAX_ROWS) ? MAX_ROWS : m;
  endfunction

  assign col_data_i = pat(int'(fetch_addr_o));

  lcd_row_scan #(.MAX_ROWS(MAX_ROWS), .COLS(COLS)) dut (.*);

  task automatic chk(input string req, input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic check_all(input string req);
    logic [MAX_ROWS-1:0] oh;
    oh = m_act ? (MAX_ROWS'(1) << m_idx) : '0;
    chk({req, " row_sel"}, 256'(row_sel_o), 256'(oh));
    chk({req, " row_idx"}, 256'(row_idx_o), 256'(m_idx));
    chk({req, " col"}, 256'(col_o), 256'(m_col));
    chk({req, " frame"}, 256'(frame_o), 256'(m_frame));
    chk({req, " fetch"}, 256'(fetch_addr_o), 256'(m_fetch));
  endtask

  task automatic model_blank();
    m_fetch = 0; m_rate = clampr(int'(mux_rate_i));
    m_act = 0; m_idx = 0; m_col = '0; m_frame = 0;
  endtask

  // one clock: inputs set at negedge, model updated, checked at next negedge
  task automatic cyc(input bit tick, input bit pd, input int rate, input string req);
    int n;
    row_tick_i = tick; pd_i = pd; mux_rate_i = 6'(rate);
    @(negedge clk);
    if (pd) model_blank();
    else begin
      m_frame = 0;
      if (tick) begin
        m_act = 1; m_idx = m_fetch; m_frame = (m_fetch == 0); m_col = pat(m_fetch);
        n = nxt(m_fetch, m_rate);
        if (n == 0) m_rate = clampr(rate);
        m_fetch = n;
      end
    end
    check_all(req);
    if (m_act) chk({req, " R2 range"}, 256'(m_idx < m_rate || row_sel_o[MAX_ROWS-1:0] == (MAX_ROWS'(1) << m_idx)), 256'(1));
  endtask

  initial begin
    #4_000_000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int seq[$];
    int r;
    void'($urandom(32'd1234));
    // reset state, POR honoured with rst_sel_i=0 (R9, R8)
    repeat (3) @(negedge clk);
    model_blank();
    check_all("R9 reset");
    por_i = 1'b0;
    repeat (2) @(negedge clk);
    cyc(1, 0, 34, "R9 first tick row0");
    chk("R9 idx0", 256'(row_idx_o), 256'(0));
    // R1 full order at 34, and odd/small lengths
    for (int k = 0; k < 40; k++) cyc(1, 0, 34, "R1 order34");
    cyc(0, 1, 7, "R7 pd");
    seq.delete();
    for (int k = 0; k < 8; k++) begin cyc(1, 0, 7, "R1 order7"); seq.push_back(int'(row_idx_o)); end
    chk("R1 seq7 pos3", 256'(seq[3]), 256'(6));
    chk("R1 seq7 pos4", 256'(seq[4]), 256'(1));
    chk("R1 seq7 wrap", 256'(seq[7]), 256'(0));
    cyc(0, 1, 1, "R7 pd");
    for (int k = 0; k < 4; k++) cyc(1, 0, 1, "R1 single row");
    // R3 clamp
    cyc(0, 1, 0, "R3 rate0");
    for (int k = 0; k < 36; k++) cyc(1, 0, 0, "R3 clamp0");
    cyc(0, 1, 50, "R3 rate50");
    for (int k = 0; k < 36; k++) cyc(1, 0, 63, "R3 clamp63");
    // R4 mid-frame change
    cyc(0, 1, 10, "R7 pd");
    for (int k = 0; k < 3; k++) cyc(1, 0, 10, "R4 pre");
    for (int k = 0; k < 20; k++) cyc(1, 0, 4, "R4 midframe change");
    // R7 ticks ignored in pd, R10 hold
    for (int k = 0; k < 5; k++) cyc(1, 1, 9, "R7 ticks ignored");
    for (int k = 0; k < 3; k++) cyc(1, 0, 9, "R6 fetch/col");
    for (int k = 0; k < 4; k++) cyc(0, 0, 9, "R10 hold");
    // R8: POR ignored when ext selected
    rst_sel_i = 1'b1; por_i = 1'b1;
    for (int k = 0; k < 4; k++) cyc(1, 0, 9, "R8 por ignored");
    por_i = 1'b0;
    // R8: ext honoured
    ext_rst_i = 1'b1;
    @(negedge clk);
    model_blank();
    check_all("R8 ext honoured");
    ext_rst_i = 1'b0;
    repeat (2) @(negedge clk);
    cyc(1, 0, 9, "R9 ext restart row0");
    // R8: ext ignored when POR selected
    rst_sel_i = 1'b0; ext_rst_i = 1'b1;
    for (int k = 0; k < 4; k++) cyc(1, 0, 9, "R8 ext ignored");
    ext_rst_i = 1'b0;
    // random mix
    r = 34;
    for (int k = 0; k < 3000; k++) begin
      if ($urandom_range(0, 99) < 3) r = $urandom_range(0, 63);
      cyc($urandom_range(0, 99) < 60, $urandom_range(0, 99) < 2, r, "R1 R2 R4 R6 random");
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule